// File: doc/BRIEF.md
# Mailbox command processor

This block is the device-side controller behind a four-byte host mailbox on a small digital I/O card. The host writes operands and a command code into four write-only outgoing byte registers. The block snapshots them, runs the command, and posts results into four read-only incoming byte registers. It shows completion by copying the executed command code into incoming byte 2, which the host polls. Commands drive eight relay outputs and sample eight isolated inputs. A strobe and read interface reaches a separate bank of eight event counters: it sets enables and edge selection, pulses clears, loads 16-bit reload and match values, and reads current counts.

The controller is a four-state machine. **ST_IDLE** waits for a host write to outgoing byte 3 (transition *accept*, which snapshots bytes 0..2). **ST_EXEC** carries out the decoded action for one cycle. It moves to **ST_CNT_WAIT** for a counter read (*fetch*) and to **ST_POST** for every other command (*done*). **ST_CNT_WAIT** captures the counter value one cycle after the read request (*capture*) and moves to ST_POST. **ST_POST** writes the result bytes and the echo, then returns to ST_IDLE (*release*). The echo only changes if the code differs from the one already there, so a host that repeats a command first issues the clear command (code 0x00), which sets the echo byte to 0x00.

Top module: `mbx_cmd_proc`

## Requirements
- R1: After reset, all relays are off, all four incoming bytes read 0x00, the counter enable and edge masks are 0x00, and no strobe is active.
- R2: Outgoing bytes 0..3 sit at offsets 0x0C..0x0F. Byte 2 holds the command code, and bytes 0 and 1 hold operands. Only a write to offset 0x0F starts a command, and the outgoing offsets read back as 0x00.
- R3: Incoming bytes 0..3 are read at offsets 0x1C..0x1F. At most four clock edges after the edge that takes the start write, incoming byte 2 holds the executed command code.
- R4: Command 0x00 sets incoming byte 2 to 0x00 and places the current 8-bit input state in incoming byte 3.
- R5: Command 0x01 loads the relay outputs from operand byte 0. Incoming bytes 0, 1 and 3 stay unchanged.
- R6: Command 0x02 returns the relay state in incoming byte 0.
- R7: Commands 0x0E and 0x0F return the 16-bit firmware and hardware version, high byte in incoming byte 1 and low byte in incoming byte 0.
- R8: Command 0x28 loads the counter enable mask from operand byte 0. Command 0x2C loads the edge mask (bit set means falling edge). Command 0x29 pulses the counter clear lines with operand byte 0 for exactly one cycle.
- R9: Commands 0x40+n and 0x48+n (n = 0..7) pulse bit n of the reload-load or match-load strobe for one cycle, with the value 256 × operand byte 1 + operand byte 0.
- R10: Command 0x2F raises the counter read request for one cycle with the counter selected by operand byte 0 bits 2:0. It takes the count one cycle later and returns it with the high byte in incoming byte 1 and the low byte in incoming byte 0.
- R11: An unrecognised command code is echoed in incoming byte 2, and the relays and other incoming bytes are unchanged.
- R12: Operands are frozen when the command is accepted. Host writes to any outgoing byte while a command runs, including offset 0x0F, affect neither the running command nor start a new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 6 | Host byte offset |
| bus_we | input | 1 | Host write enable |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Host read data for the addressed offset |
| din | input | 8 | Isolated digital input state |
| relay | output | 8 | Relay drive outputs |
| cnt_en | output | 8 | Counter enable mask |
| cnt_fall | output | 8 | Counter edge select, 1 = falling |
| cnt_clr | output | 8 | One-cycle counter clear pulses |
| cnt_ld_rst | output | 8 | One-cycle reload-value load strobes |
| cnt_ld_match | output | 8 | One-cycle match-value load strobes |
| cnt_val | output | 16 | Value for reload/match loads |
| cnt_rd_en | output | 1 | Counter read request |
| cnt_rd_sel | output | 3 | Counter selected for reading |
| cnt_rd_data | input | 16 | Count returned one cycle after the request |

## Verification
A host write to the outgoing registers can land in the same cycle as the execution of the command that those registers started. Two cases matter: an operand rewrite on the edge right after the start, and a second start write while the result is being posted. The bench drives these writes on consecutive clock edges behind the start. It judges the outcome by the relay value and the echo byte, which must reflect the first command's frozen operands and show no sign of the second command. The clear command is also used between repeated codes so that a completed echo cannot be mistaken for a stale one.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_EXEC,
        ST_CNT_WAIT,
        ST_POST
    } mbx_state_e;

    localparam int MBX_BYTES  = 4;
    localparam int OPC_SLOT   = 2;

    localparam logic [7:0] CMD_CLEAR     = 8'h00;
    localparam logic [7:0] CMD_RELAY_SET = 8'h01;
    localparam logic [7:0] CMD_RELAY_GET = 8'h02;
    localparam logic [7:0] CMD_FW_VER    = 8'h0E;
    localparam logic [7:0] CMD_HW_VER    = 8'h0F;
    localparam logic [7:0] CMD_CNT_EN    = 8'h28;
    localparam logic [7:0] CMD_CNT_CLR   = 8'h29;
    localparam logic [7:0] CMD_CNT_EDGE  = 8'h2C;
    localparam logic [7:0] CMD_CNT_READ  = 8'h2F;
    localparam int         CMD_LD_RST_BASE   = 'h40;
    localparam int         CMD_LD_MATCH_BASE = 'h48;

endpackage

// File: rtl/mbx_host_regs.sv
module mbx_host_regs #(
    parameter int ADDR_W = 6,
    parameter int DW     = 8,
    parameter int NB     = 4,
    parameter logic [ADDR_W-1:0] OUT_BASE = 'h0C,
    parameter logic [ADDR_W-1:0] IN_BASE  = 'h1C
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_we,
    input  logic [DW-1:0]        bus_wdata,
    output logic [DW-1:0]        bus_rdata,
    input  logic [NB-1:0]        ib_we,
    input  logic [NB*DW-1:0]     ib_wdata,
    output logic [NB*DW-1:0]     ob_q,
    output logic [NB*DW-1:0]     ib_q,
    output logic                 start_o
);

    logic [NB-1:0] wr_hit;
    logic [NB-1:0] rd_hit;

    generate
        for (genvar b = 0; b < NB; b++) begin : g_dec
            assign wr_hit[b] = bus_we && (bus_addr == OUT_BASE + ADDR_W'(b));
            assign rd_hit[b] = (bus_addr == IN_BASE + ADDR_W'(b));
        end
    endgenerate

    assign start_o = wr_hit[NB-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ob_q <= '0;
            ib_q <= '0;
        end else begin
            for (int b = 0; b < NB; b++) begin
                if (wr_hit[b]) ob_q[b*DW +: DW] <= bus_wdata;
                if (ib_we[b])  ib_q[b*DW +: DW] <= ib_wdata[b*DW +: DW];
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        for (int b = 0; b < NB; b++) begin
            if (rd_hit[b]) bus_rdata = bus_rdata | ib_q[b*DW +: DW];
        end
    end

endmodule

// File: rtl/mbx_ctrl.sv
module mbx_ctrl
    import mbx_pkg::*;
#(
    parameter int DW   = 8,
    parameter int NCNT = 8,
    parameter logic [2*DW-1:0] FW_VER = 16'h0103,
    parameter logic [2*DW-1:0] HW_VER = 16'h0A02,
    localparam int NB   = MBX_BYTES,
    localparam int SELW = $clog2(NCNT)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic [NB*DW-1:0]     ob_i,
    input  logic [DW-1:0]        din_i,
    input  logic [2*DW-1:0]      cnt_rd_data_i,
    output logic [DW-1:0]        relay_o,
    output logic [NCNT-1:0]      cnt_en_o,
    output logic [NCNT-1:0]      cnt_fall_o,
    output logic [NCNT-1:0]      cnt_clr_o,
    output logic                 cnt_rd_en_o,
    output logic [SELW-1:0]      cnt_rd_sel_o,
    output logic                 exec_o,
    output logic [DW-1:0]        cmd_o,
    output logic [2*DW-1:0]      op_o,
    output logic [NB-1:0]        ib_we_o,
    output logic [NB*DW-1:0]     ib_wdata_o,
    output mbx_state_e           state_o
);

    localparam int LAT_MAX = 3;

    mbx_state_e              state_q, state_d;
    logic [DW-1:0]           cmd_q, op0_q, op1_q;
    logic [NB-1:0][DW-1:0]   res_q;
    logic [NB-1:0]           res_mask_q;
    logic [DW-1:0]           relay_q;
    logic [NCNT-1:0]         en_q, fall_q;
    logic [2:0]              busy_cnt_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions: accept, fetch, done, capture, release
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (start_i) state_d = ST_EXEC;
            ST_EXEC:     state_d = (cmd_q == CMD_CNT_READ) ? ST_CNT_WAIT : ST_POST;
            ST_CNT_WAIT: state_d = ST_POST;
            ST_POST:     state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q      <= '0;
            op0_q      <= '0;
            op1_q      <= '0;
            res_q      <= '0;
            res_mask_q <= '0;
            relay_q    <= '0;
            en_q       <= '0;
            fall_q     <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        cmd_q      <= ob_i[OPC_SLOT*DW +: DW];
                        op0_q      <= ob_i[0 +: DW];
                        op1_q      <= ob_i[DW +: DW];
                        res_mask_q <= '0;
                    end
                end
                ST_EXEC: begin
                    unique case (cmd_q)
                        CMD_CLEAR: begin
                            res_q[3]   <= din_i;
                            res_mask_q <= 4'b1000;
                        end
                        CMD_RELAY_SET: relay_q <= op0_q;
                        CMD_RELAY_GET: begin
                            res_q[0]   <= relay_q;
                            res_mask_q <= 4'b0001;
                        end
                        CMD_FW_VER: begin
                            res_q[0]   <= FW_VER[DW-1:0];
                            res_q[1]   <= FW_VER[2*DW-1:DW];
                            res_mask_q <= 4'b0011;
                        end
                        CMD_HW_VER: begin
                            res_q[0]   <= HW_VER[DW-1:0];
                            res_q[1]   <= HW_VER[2*DW-1:DW];
                            res_mask_q <= 4'b0011;
                        end
                        CMD_CNT_EN:    en_q   <= op0_q[NCNT-1:0];
                        CMD_CNT_EDGE:  fall_q <= op0_q[NCNT-1:0];
                        CMD_CNT_READ:  res_mask_q <= 4'b0011;
                        default: ;
                    endcase
                end
                ST_CNT_WAIT: begin
                    res_q[0] <= cnt_rd_data_i[DW-1:0];
                    res_q[1] <= cnt_rd_data_i[2*DW-1:DW];
                end
                ST_POST: ;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        exec_o       = (state_q == ST_EXEC);
        cnt_rd_en_o  = exec_o && (cmd_q == CMD_CNT_READ);
        cnt_rd_sel_o = op0_q[SELW-1:0];
        cnt_clr_o    = (exec_o && cmd_q == CMD_CNT_CLR) ? op0_q[NCNT-1:0] : '0;
        ib_we_o      = '0;
        ib_wdata_o   = '0;
        if (state_q == ST_POST) begin
            ib_we_o = res_mask_q;
            ib_we_o[OPC_SLOT] = 1'b1;
            for (int b = 0; b < NB; b++) ib_wdata_o[b*DW +: DW] = res_q[b];
            ib_wdata_o[OPC_SLOT*DW +: DW] = cmd_q;
        end
    end

    assign relay_o    = relay_q;
    assign cnt_en_o   = en_q;
    assign cnt_fall_o = fall_q;
    assign cmd_o      = cmd_q;
    assign op_o       = {op1_q, op0_q};
    assign state_o    = state_q;

    // busy-cycle counter for the latency bound
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  busy_cnt_q <= '0;
        else if (state_q == ST_IDLE) busy_cnt_q <= '0;
        else                         busy_cnt_q <= busy_cnt_q + 3'd1;
    end

    p_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |-> (busy_cnt_q < 3'(LAT_MAX)));

    p_relay_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (relay_q != $past(relay_q)) |-> $past(state_q == ST_EXEC && cmd_q == CMD_RELAY_SET));

    p_rd_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_rd_en_o |=> !cnt_rd_en_o);

    p_busy_start_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && start_i) |=> $stable(cmd_q));

endmodule

// File: rtl/mbx_cnt_strobe.sv
module mbx_cnt_strobe
    import mbx_pkg::*;
#(
    parameter int DW   = 8,
    parameter int NCNT = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             exec_i,
    input  logic [DW-1:0]    cmd_i,
    output logic [NCNT-1:0]  ld_rst_o,
    output logic [NCNT-1:0]  ld_match_o
);

    generate
        for (genvar n = 0; n < NCNT; n++) begin : g_chan
            assign ld_rst_o[n]   = exec_i && (cmd_i == DW'(CMD_LD_RST_BASE + n));
            assign ld_match_o[n] = exec_i && (cmd_i == DW'(CMD_LD_MATCH_BASE + n));
        end
    endgenerate

    p_ld_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (|{ld_rst_o, ld_match_o}) |=> !(|{ld_rst_o, ld_match_o}));

endmodule

// File: rtl/mbx_cmd_proc.sv
module mbx_cmd_proc
    import mbx_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DW     = 8,
    parameter int NCNT   = 8,
    parameter logic [2*DW-1:0] FW_VER = 16'h0103,
    parameter logic [2*DW-1:0] HW_VER = 16'h0A02,
    localparam int NB   = MBX_BYTES,
    localparam int SELW = $clog2(NCNT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    input  logic [DW-1:0]     din,
    output logic [DW-1:0]     relay,
    output logic [NCNT-1:0]   cnt_en,
    output logic [NCNT-1:0]   cnt_fall,
    output logic [NCNT-1:0]   cnt_clr,
    output logic [NCNT-1:0]   cnt_ld_rst,
    output logic [NCNT-1:0]   cnt_ld_match,
    output logic [2*DW-1:0]   cnt_val,
    output logic              cnt_rd_en,
    output logic [SELW-1:0]   cnt_rd_sel,
    input  logic [2*DW-1:0]   cnt_rd_data
);

    logic [NB*DW-1:0] ob_q, ib_q, ib_wdata;
    logic [NB-1:0]    ib_we;
    logic             start, exec;
    logic [DW-1:0]    cmd;
    mbx_state_e       state;

    mbx_host_regs #(
        .ADDR_W   (ADDR_W),
        .DW       (DW),
        .NB       (NB),
        .OUT_BASE (ADDR_W'('h0C)),
        .IN_BASE  (ADDR_W'('h1C))
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .ib_we     (ib_we),
        .ib_wdata  (ib_wdata),
        .ob_q      (ob_q),
        .ib_q      (ib_q),
        .start_o   (start)
    );

    mbx_ctrl #(
        .DW     (DW),
        .NCNT   (NCNT),
        .FW_VER (FW_VER),
        .HW_VER (HW_VER)
    ) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start),
        .ob_i          (ob_q),
        .din_i         (din),
        .cnt_rd_data_i (cnt_rd_data),
        .relay_o       (relay),
        .cnt_en_o      (cnt_en),
        .cnt_fall_o    (cnt_fall),
        .cnt_clr_o     (cnt_clr),
        .cnt_rd_en_o   (cnt_rd_en),
        .cnt_rd_sel_o  (cnt_rd_sel),
        .exec_o        (exec),
        .cmd_o         (cmd),
        .op_o          (cnt_val),
        .ib_we_o       (ib_we),
        .ib_wdata_o    (ib_wdata),
        .state_o       (state)
    );

    mbx_cnt_strobe #(
        .DW   (DW),
        .NCNT (NCNT)
    ) u_strobe (
        .clk        (clk),
        .rst_n      (rst_n),
        .exec_i     (exec),
        .cmd_i      (cmd),
        .ld_rst_o   (cnt_ld_rst),
        .ld_match_o (cnt_ld_match)
    );

    p_echo_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_POST) |=> (ib_q[OPC_SLOT*DW +: DW] == $past(cmd)));

endmodule

// File: tb/mbx_cmd_proc_bench.sv
`timescale 1ns/100ps
module mbx_cmd_proc_bench;

    localparam logic [15:0] FW = 16'h0103;
    localparam logic [15:0] HW = 16'h0A02;
    localparam logic [5:0] OB0 = 6'h0C, OB1 = 6'h0D, OB2 = 6'h0E, OB3 = 6'h0F;
    localparam logic [5:0] IB0 = 6'h1C;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [5:0]  bus_addr;
    logic        bus_we;
    logic [7:0]  bus_wdata, bus_rdata, din, relay;
    logic [7:0]  cnt_en, cnt_fall, cnt_clr, cnt_ld_rst, cnt_ld_match;
    logic [15:0] cnt_val, cnt_rd_data;
    logic        cnt_rd_en;
    logic [2:0]  cnt_rd_sel;

    always #2.5 clk = ~clk;

    mbx_cmd_proc #(.FW_VER(FW), .HW_VER(HW)) u_mbx_cmd_proc (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .din(din), .relay(relay),
        .cnt_en(cnt_en), .cnt_fall(cnt_fall), .cnt_clr(cnt_clr),
        .cnt_ld_rst(cnt_ld_rst), .cnt_ld_match(cnt_ld_match), .cnt_val(cnt_val),
        .cnt_rd_en(cnt_rd_en), .cnt_rd_sel(cnt_rd_sel), .cnt_rd_data(cnt_rd_data)
    );

    function automatic logic [15:0] cnt_model(input logic [2:0] s);
        return 16'hC000 + 16'(s) * 16'h0123;
    endfunction

    // counter bank model: data one cycle after the request
    logic       rd_pend = 1'b0;
    logic [2:0] rd_sel_l = '0;
    initial cnt_rd_data = '0;
    always @(posedge clk) if (rd_pend) cnt_rd_data <= cnt_model(rd_sel_l);

    // strobe observers, sampled mid-cycle
    int n_clr = 0, n_ldr = 0, n_ldm = 0, n_rd = 0;
    logic [7:0]  last_clr, last_ldr, last_ldm;
    logic [15:0] last_val;
    logic [2:0]  last_sel;
    always @(negedge clk) begin
        rd_pend  = cnt_rd_en;
        rd_sel_l = cnt_rd_sel;
        if (|cnt_clr)      begin n_clr++; last_clr = cnt_clr; end
        if (|cnt_ld_rst)   begin n_ldr++; last_ldr = cnt_ld_rst; last_val = cnt_val; end
        if (|cnt_ld_match) begin n_ldm++; last_ldm = cnt_ld_match; last_val = cnt_val; end
        if (cnt_rd_en)     begin n_rd++; last_sel = cnt_rd_sel; end
    end

    int n_tests = 0, n_fail = 0;
    bit finished = 1'b0;

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic rd(input logic [5:0] a, output logic [7:0] d);
        bus_addr = a;
        #0.2;
        d = bus_rdata;
    endtask

    task automatic wr_now(input logic [5:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    endtask

    task automatic wr_idle();
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    // scoreboard
    typedef struct {
        logic [31:0] ib;
        logic [7:0]  relay;
        logic [7:0]  en;
        logic [7:0]  fall;
        string       req;
    } exp_t;
    exp_t sbq[$];
    event go, done;

    logic [7:0] m_ib [4];
    logic [7:0] m_relay = '0, m_en = '0, m_fall = '0;

    function automatic void model(input logic [7:0] c, input logic [7:0] o0);
        case (c)
            8'h00: m_ib[3] = din;
            8'h01: m_relay = o0;
            8'h02: m_ib[0] = m_relay;
            8'h0E: {m_ib[1], m_ib[0]} = FW;
            8'h0F: {m_ib[1], m_ib[0]} = HW;
            8'h28: m_en = o0;
            8'h2C: m_fall = o0;
            8'h2F: {m_ib[1], m_ib[0]} = cnt_model(o0[2:0]);
            default: ;
        endcase
        m_ib[2] = c;
    endfunction

    task automatic push_and_wait(input string req);
        exp_t e;
        e.ib = {m_ib[3], m_ib[2], m_ib[1], m_ib[0]};
        e.relay = m_relay; e.en = m_en; e.fall = m_fall; e.req = req;
        sbq.push_back(e);
        -> go;
        @(done);
    endtask

    task automatic issue(input logic [7:0] c, input logic [7:0] o0, input logic [7:0] o1, input string req);
        wr_now(OB0, o0); wr_now(OB1, o1); wr_now(OB2, c); wr_now(OB3, 8'h00);
        wr_idle();
        model(c, o0);
        push_and_wait(req);
    endtask

    initial begin : monitor
        forever begin
            exp_t e;
            logic [7:0] d;
            @(go);
            repeat (6) @(posedge clk);
            @(negedge clk);
            e = sbq.pop_front();
            for (int b = 0; b < 4; b++) begin
                rd(IB0 + 6'(b), d);
                chk(e.req, $sformatf("incoming byte %0d", b), 32'(d), 32'(e.ib[b*8 +: 8]));
            end
            chk(e.req, "relay", 32'(relay), 32'(e.relay));
            chk(e.req, "cnt_en", 32'(cnt_en), 32'(e.en));
            chk(e.req, "cnt_fall", 32'(cnt_fall), 32'(e.fall));
            -> done;
        end
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : driver
        logic [7:0] d;
        int c0;
        for (int b = 0; b < 4; b++) m_ib[b] = '0;
        rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0; din = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int b = 0; b < 4; b++) begin
            rd(IB0 + 6'(b), d);
            chk("R1", "incoming after reset", 32'(d), 32'h0);
        end
        chk("R1", "relay after reset", 32'(relay), 32'h0);
        chk("R1", "masks after reset", {16'h0, cnt_en, cnt_fall}, 32'h0);
        chk("R1", "strobes after reset", {cnt_clr, cnt_ld_rst, cnt_ld_match, 7'h0, cnt_rd_en}, 32'h0);

        // R5 relay load, R3 echo
        issue(8'h01, 8'hA5, 8'h00, "R5");
        // R6 relay readback
        issue(8'h02, 8'h00, 8'h00, "R6");
        // R4 clear with input sample
        din = 8'h3C;
        issue(8'h00, 8'h00, 8'h00, "R4");

        // R2 no start without write to 0x0F; outgoing reads give zero
        wr_now(OB0, 8'h99); wr_now(OB2, 8'h01); wr_idle();
        repeat (6) @(negedge clk);
        chk("R2", "relay without start", 32'(relay), 32'hA5);
        rd(OB0, d);
        chk("R2", "outgoing readback", 32'(d), 32'h0);
        rd(IB0 + 6'd2, d);
        chk("R2", "echo without start", 32'(d), 32'h0);

        // R7 versions
        issue(8'h0E, 8'h00, 8'h00, "R7");
        issue(8'h0F, 8'h00, 8'h00, "R7");

        // R8 counter enable, edge, clear pulse
        issue(8'h28, 8'h0F, 8'h00, "R8");
        issue(8'h2C, 8'hF0, 8'h00, "R8");
        c0 = n_clr;
        issue(8'h29, 8'h81, 8'h00, "R8");
        chk("R8", "clear pulse count", 32'(n_clr - c0), 32'd1);
        chk("R8", "clear pulse mask", 32'(last_clr), 32'h81);

        // R9 reload and match loads
        c0 = n_ldr;
        issue(8'h43, 8'h34, 8'h12, "R9");
        chk("R9", "reload strobe count", 32'(n_ldr - c0), 32'd1);
        chk("R9", "reload strobe bit", 32'(last_ldr), 32'h08);
        chk("R9", "reload value", 32'(last_val), 32'h1234);
        c0 = n_ldm;
        issue(8'h4F, 8'hEF, 8'hBE, "R9");
        chk("R9", "match strobe count", 32'(n_ldm - c0), 32'd1);
        chk("R9", "match strobe bit", 32'(last_ldm), 32'h80);
        chk("R9", "match value", 32'(last_val), 32'hBEEF);

        // R10 counter read
        c0 = n_rd;
        issue(8'h2F, 8'h05, 8'h00, "R10");
        chk("R10", "read request count", 32'(n_rd - c0), 32'd1);
        chk("R10", "read select", 32'(last_sel), 32'd5);

        // R11 unknown code
        issue(8'h77, 8'h5A, 8'h00, "R11");

        // R12 start write while posting is discarded
        wr_now(OB0, 8'h22); wr_now(OB2, 8'h01); wr_now(OB3, 8'h00);
        wr_now(OB2, 8'h02); wr_now(OB3, 8'h00); wr_idle();
        model(8'h01, 8'h22);
        push_and_wait("R12");

        issue(8'h00, 8'h00, 8'h00, "R4");

        // R12 operand rewrite right after start is not seen
        wr_now(OB0, 8'h11); wr_now(OB2, 8'h01); wr_now(OB3, 8'h00);
        wr_now(OB0, 8'hEE); wr_idle();
        model(8'h01, 8'h11);
        push_and_wait("R12");

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule